// File: doc/BRIEF.md
# Timing-Predicted Neural Network Sequencer

This block is the central controller of a layered neural datapath that learns online. It contains no handshakes. It counts clock cycles inside each iteration and compares that count against a set of milestones. The milestones are fixed at elaboration from the layer count, the fan-in of each layer and the latency of each stage. At every milestone it raises one-cycle enable pulses:

- forward start of a layer;
- activation start of a layer;
- the two training-preparation steps of a layer's training unit (learning-rate product and activation derivative);
- the backward gradient step of a layer's training unit.

It also drives the select of the multiplexer that lends the single shared backpropagation arithmetic unit to one layer at a time.

The outputs are Mealy. In the cycle where `start_i` is seen while the block is idle, the offset-0 enables fire in that same cycle. The training mode is sampled in that cycle and held for the whole iteration.

In training mode, the preparation steps run alongside the forward pass. The backward pass then walks from the output layer down to the first hidden layer, and the weights are updated after every example. In inference mode every training milestone is skipped, and the iteration ends as soon as the output layer's activation is done.

Top module: `nseq_ctrl`

## Requirements

Definitions used below:
- L = `LAYERS`.
- STAGE = `FANIN*MAC_LAT + ACT_LAT`.
- FWD_END = L*STAGE.
- Offset k counts cycles from the cycle in which `start_i` is accepted while idle, which is offset 0.
- Layer 0 is the first hidden layer and layer L-1 is the output layer.
- Bit l of each per-layer vector belongs to layer l.

Requirements:
- R1: While `rst` is high, every output is 0, whatever `start_i` does.
- R2: `fwd_en_o[l]` is high for exactly one cycle, at offset l*STAGE, in both modes.
- R3: `act_en_o[l]` is high for exactly one cycle, at offset l*STAGE + FANIN*MAC_LAT, in both modes.
- R4: In training mode, `eta_en_o[l]` pulses at offset l*STAGE and `deriv_en_o[l]` pulses at offset (l+1)*STAGE. In inference mode neither ever pulses.
- R5: In training mode, `bp_en_o[l]` pulses once, at offset FWD_END + (L-1-l)*BP_LAT. The output layer therefore goes first and layer 0 goes last. In inference mode `bp_en_o` stays 0.
- R6: In training mode, for offsets in [FWD_END, FWD_END + L*BP_LAT), `bp_sel_valid_o` is 1. In that window `bp_sel_o` equals L-1-floor((k-FWD_END)/BP_LAT), the index of the owning layer. Outside that window, and at all times in inference mode, both are 0. At most one bit of `bp_en_o` is ever high.
- R7: `done_o` is high for one cycle. In training mode that cycle is offset FWD_END + L*BP_LAT; in inference mode it is offset FWD_END. The following cycle is idle, so if `start_i` is high then, that cycle is offset 0 of a new iteration, with no gap.
- R8: While an iteration runs, `start_i` pulses and changes on `train_mode_i` have no effect on any output.
- R9: A reset in the middle of an iteration aborts it. After reset, outputs stay 0 until the next `start_i`, which begins again at offset 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an iteration when idle |
| train_mode_i | input | 1 | 1 = training, 0 = inference; sampled at offset 0 |
| fwd_en_o | output | LAYERS | Forward computation start, per layer |
| act_en_o | output | LAYERS | Activation stage start, per layer |
| eta_en_o | output | LAYERS | Learning-rate input product start, per layer |
| deriv_en_o | output | LAYERS | Activation derivative start, per layer |
| bp_en_o | output | LAYERS | Backward gradient step start, per layer |
| bp_sel_o | output | SW | Owning layer of the shared backpropagation unit |
| bp_sel_valid_o | output | 1 | Shared unit currently owned |
| done_o | output | 1 | Iteration complete, one cycle |

## Verification

The bench compares every output in every cycle of an iteration against offsets it computes from the parameters. This covers both modes, back-to-back iterations with `start_i` held high, a reset in mid-iteration, and a reset held with `start_i` high.

Each of these corner cases catches a specific fault:
- A design whose counter is off by one shows every enable one cycle late.
- A design that does not latch the mode at start either loses the backward pass when `train_mode_i` drops mid-iteration, or gains one when it rises.
- A design that restarts its counter on a fresh `start_i` repeats the early milestones.
- A design that inserts an idle cycle between back-to-back iterations lags the whole second iteration by one cycle.
- A mistake in the select arithmetic shows up at the boundaries of the backward windows, where ownership moves from one layer to the next.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // cycles one layer occupies in the forward pass
    function automatic int stage_cycles(input int fanin, input int mac_lat, input int act_lat);
        return fanin * mac_lat + act_lat;
    endfunction

    // offset at which layer `layer` receives its input
    function automatic int layer_in_at(input int layer, input int stage);
        return layer * stage;
    endfunction

    // offset of the first backward cycle owned by layer `layer`
    function automatic int bwd_at(input int layer, input int layers, input int stage, input int bp_lat);
        return layers * stage + (layers - 1 - layer) * bp_lat;
    endfunction

    // final offset of an iteration
    function automatic int last_at(input int layers, input int stage, input int bp_lat, input bit train);
        return train ? layers * stage + layers * bp_lat : layers * stage;
    endfunction

    function automatic int width_for(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/nseq_timer.sv
module nseq_timer #(
    parameter int LAYERS  = 3,
    parameter int FANIN   = 4,
    parameter int MAC_LAT = 1,
    parameter int ACT_LAT = 5,
    parameter int BP_LAT  = 6,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          train_mode_i,
    output logic          active_o,
    output logic          train_o,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    import nseq_pkg::*;

    localparam int STAGE   = stage_cycles(FANIN, MAC_LAT, ACT_LAT);
    localparam int END_TR  = last_at(LAYERS, STAGE, BP_LAT, 1'b1);
    localparam int END_INF = last_at(LAYERS, STAGE, BP_LAT, 1'b0);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          train_q;
    logic [CW-1:0] last_cnt;
    logic          running;

    always_comb begin
        running  = (state_q == ST_RUN);
        active_o = !rst && (running || start_i);
        cnt_o    = running ? cnt_q : '0;
        train_o  = running ? train_q : train_mode_i;
        last_cnt = train_o ? CW'(END_TR) : CW'(END_INF);
        done_o   = active_o && (cnt_o == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            train_q <= 1'b0;
        end else if (active_o) begin
            if (!running) begin
                train_q <= train_mode_i;
            end
            if (done_o) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else begin
                state_q <= ST_RUN;
                cnt_q   <= cnt_o + CW'(1);
            end
        end
    end

endmodule

// File: rtl/nseq_fwd_dec.sv
module nseq_fwd_dec #(
    parameter int LAYERS  = 3,
    parameter int FANIN   = 4,
    parameter int MAC_LAT = 1,
    parameter int ACT_LAT = 5,
    parameter int CW      = 6
) (
    input  logic              active_i,
    input  logic              train_i,
    input  logic [CW-1:0]     cnt_i,
    output logic [LAYERS-1:0] fwd_en_o,
    output logic [LAYERS-1:0] act_en_o,
    output logic [LAYERS-1:0] eta_en_o,
    output logic [LAYERS-1:0] deriv_en_o
);
    import nseq_pkg::*;

    localparam int STAGE   = stage_cycles(FANIN, MAC_LAT, ACT_LAT);
    localparam int MAC_SPAN = FANIN * MAC_LAT;

    for (genvar g = 0; g < LAYERS; g++) begin : g_layer
        localparam int IN_AT  = layer_in_at(g, STAGE);
        localparam int ACT_AT = IN_AT + MAC_SPAN;
        localparam int OUT_AT = layer_in_at(g + 1, STAGE);

        logic at_in, at_act, at_out;

        always_comb begin
            at_in  = active_i && (cnt_i == CW'(IN_AT));
            at_act = active_i && (cnt_i == CW'(ACT_AT));
            at_out = active_i && (cnt_i == CW'(OUT_AT));
        end

        assign fwd_en_o[g]   = at_in;
        assign act_en_o[g]   = at_act;
        assign eta_en_o[g]   = at_in && train_i;
        assign deriv_en_o[g] = at_out && train_i;
    end

endmodule

// File: rtl/nseq_bp_sched.sv
module nseq_bp_sched #(
    parameter int LAYERS = 3,
    parameter int STAGE  = 9,
    parameter int BP_LAT = 6,
    parameter int CW     = 6,
    parameter int SW     = 2
) (
    input  logic              active_i,
    input  logic              train_i,
    input  logic [CW-1:0]     cnt_i,
    output logic [LAYERS-1:0] bp_en_o,
    output logic [SW-1:0]     bp_sel_o,
    output logic              bp_sel_valid_o
);
    import nseq_pkg::*;

    logic [LAYERS-1:0] owns;

    for (genvar g = 0; g < LAYERS; g++) begin : g_win
        localparam int LO = bwd_at(g, LAYERS, STAGE, BP_LAT);
        localparam int HI = LO + BP_LAT;

        logic live;
        assign live       = active_i && train_i;
        assign owns[g]    = live && (cnt_i >= CW'(LO)) && (cnt_i < CW'(HI));
        assign bp_en_o[g] = live && (cnt_i == CW'(LO));
    end

    always_comb begin
        bp_sel_o = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (owns[l]) begin
                bp_sel_o = SW'(l);
            end
        end
        bp_sel_valid_o = |owns;
    end

endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl #(
    parameter int LAYERS  = 3,
    parameter int FANIN   = 4,
    parameter int MAC_LAT = 1,
    parameter int ACT_LAT = 5,
    parameter int BP_LAT  = 6,
    localparam int SW     = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              train_mode_i,
    output logic [LAYERS-1:0] fwd_en_o,
    output logic [LAYERS-1:0] act_en_o,
    output logic [LAYERS-1:0] eta_en_o,
    output logic [LAYERS-1:0] deriv_en_o,
    output logic [LAYERS-1:0] bp_en_o,
    output logic [SW-1:0]     bp_sel_o,
    output logic              bp_sel_valid_o,
    output logic              done_o
);
    import nseq_pkg::*;

    localparam int STAGE = stage_cycles(FANIN, MAC_LAT, ACT_LAT);
    localparam int CW    = width_for(last_at(LAYERS, STAGE, BP_LAT, 1'b1));

    logic          active;
    logic          train;
    logic [CW-1:0] cnt;

    nseq_timer #(
        .LAYERS(LAYERS), .FANIN(FANIN), .MAC_LAT(MAC_LAT),
        .ACT_LAT(ACT_LAT), .BP_LAT(BP_LAT), .CW(CW)
    ) u_timer (
        .clk(clk), .rst(rst), .start_i(start_i), .train_mode_i(train_mode_i),
        .active_o(active), .train_o(train), .cnt_o(cnt), .done_o(done_o)
    );

    nseq_fwd_dec #(
        .LAYERS(LAYERS), .FANIN(FANIN), .MAC_LAT(MAC_LAT),
        .ACT_LAT(ACT_LAT), .CW(CW)
    ) u_fwd (
        .active_i(active), .train_i(train), .cnt_i(cnt),
        .fwd_en_o(fwd_en_o), .act_en_o(act_en_o),
        .eta_en_o(eta_en_o), .deriv_en_o(deriv_en_o)
    );

    nseq_bp_sched #(
        .LAYERS(LAYERS), .STAGE(STAGE), .BP_LAT(BP_LAT), .CW(CW), .SW(SW)
    ) u_bp (
        .active_i(active), .train_i(train), .cnt_i(cnt),
        .bp_en_o(bp_en_o), .bp_sel_o(bp_sel_o), .bp_sel_valid_o(bp_sel_valid_o)
    );

endmodule

// File: rtl/nseq_chk.sv
module nseq_chk #(
    parameter int LAYERS = 3,
    parameter int SW     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [LAYERS-1:0] fwd_en_o,
    input logic [LAYERS-1:0] bp_en_o,
    input logic [SW-1:0]     bp_sel_o,
    input logic              bp_sel_valid_o,
    input logic              done_o
);

    // R2
    fwd_single_layer_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fwd_en_o));

    // R6
    bp_single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bp_en_o));

    // R6
    bp_en_has_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (bp_en_o != '0) |-> bp_sel_valid_o);

    // R5
    out_layer_first_chk: assert property (@(posedge clk) disable iff (rst)
        bp_en_o[LAYERS-1] |-> (bp_sel_o == SW'(LAYERS - 1)));

    // R6
    sel_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        bp_sel_valid_o |-> (int'(bp_sel_o) < LAYERS));

    // R7
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind nseq_ctrl nseq_chk #(.LAYERS(LAYERS), .SW(SW)) u_nseq_chk (
    .clk(clk), .rst(rst), .fwd_en_o(fwd_en_o), .bp_en_o(bp_en_o),
    .bp_sel_o(bp_sel_o), .bp_sel_valid_o(bp_sel_valid_o), .done_o(done_o)
);

// File: tb/tb_nseq_ctrl.sv
module tb_nseq_ctrl;

    localparam int L     = 3;
    localparam int FANIN = 4;
    localparam int MAC   = 1;
    localparam int ACT   = 5;
    localparam int BP    = 6;
    localparam int SW    = 2;
    localparam int STAGE = FANIN * MAC + ACT;
    localparam int TF    = L * STAGE;
    localparam int TE    = TF + L * BP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          train_mode_i = 1'b0;
    logic [L-1:0]  fwd_en_o, act_en_o, eta_en_o, deriv_en_o, bp_en_o;
    logic [SW-1:0] bp_sel_o;
    logic          bp_sel_valid_o, done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nseq_ctrl #(
        .LAYERS(L), .FANIN(FANIN), .MAC_LAT(MAC), .ACT_LAT(ACT), .BP_LAT(BP)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .train_mode_i(train_mode_i),
        .fwd_en_o(fwd_en_o), .act_en_o(act_en_o), .eta_en_o(eta_en_o),
        .deriv_en_o(deriv_en_o), .bp_en_o(bp_en_o), .bp_sel_o(bp_sel_o),
        .bp_sel_valid_o(bp_sel_valid_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input string ctx, input int k,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s k=%0d actual=%h expected=%h", tag, ctx, k, act, exp);
        end
    endtask

    // k < 0 means idle or in reset: everything must be zero
    task automatic compare(input int k, input bit tr, input string ctx, input string force_tag);
        logic [L-1:0]  ef, ea, ee, ed, eb;
        logic          ev, edn;
        logic [SW-1:0] es;
        ef = '0; ea = '0; ee = '0; ed = '0; eb = '0; ev = 1'b0; es = '0; edn = 1'b0;
        if (k >= 0) begin
            for (int l = 0; l < L; l++) begin
                ef[l] = (k == l * STAGE);
                ea[l] = (k == l * STAGE + FANIN * MAC);
                ee[l] = tr && (k == l * STAGE);
                ed[l] = tr && (k == (l + 1) * STAGE);
                eb[l] = tr && (k == TF + (L - 1 - l) * BP);
            end
            ev  = tr && (k >= TF) && (k < TE);
            es  = ev ? SW'(L - 1 - (k - TF) / BP) : '0;
            edn = (k == (tr ? TE : TF));
        end
        chk(force_tag != "" ? force_tag : "R2", ctx, k, 16'(fwd_en_o), 16'(ef));
        chk(force_tag != "" ? force_tag : "R3", ctx, k, 16'(act_en_o), 16'(ea));
        chk(force_tag != "" ? force_tag : "R4", ctx, k, 16'({eta_en_o, deriv_en_o}), 16'({ee, ed}));
        chk(force_tag != "" ? force_tag : "R5", ctx, k, 16'(bp_en_o), 16'(eb));
        chk(force_tag != "" ? force_tag : "R6", ctx, k, 16'({bp_sel_valid_o, bp_sel_o}), 16'({ev, es}));
        chk(force_tag != "" ? force_tag : "R7", ctx, k, 16'(done_o), 16'(edn));
    endtask

    task automatic cyc(input int k, input bit tr, input logic st, input logic md,
                       input logic rs, input string ctx, input string tag);
        @(negedge clk);
        rst = rs;
        start_i = st;
        train_mode_i = md;
        #5;
        compare(k, tr, ctx, tag);
    endtask

    initial begin
        // R1: reset held while start requests
        for (int i = 0; i < 4; i++) cyc(-1, 1'b1, 1'b1, 1'b1, 1'b1, "reset", "R1");
        cyc(-1, 1'b0, 1'b0, 1'b0, 1'b0, "idle", "R1");

        // training iteration
        cyc(0, 1'b1, 1'b1, 1'b1, 1'b0, "train", "");
        for (int k = 1; k <= TE; k++) cyc(k, 1'b1, 1'b0, 1'b1, 1'b0, "train", "");
        for (int i = 0; i < 3; i++) cyc(-1, 1'b0, 1'b0, 1'b1, 1'b0, "post-train", "R7");

        // inference iteration
        cyc(0, 1'b0, 1'b1, 1'b0, 1'b0, "infer", "");
        for (int k = 1; k <= TF; k++) cyc(k, 1'b0, 1'b0, 1'b0, 1'b0, "infer", "");
        for (int i = 0; i < 3; i++) cyc(-1, 1'b0, 1'b0, 1'b0, 1'b0, "post-infer", "R7");

        // R7: back-to-back training iterations, start held high
        for (int it = 0; it < 2; it++)
            for (int k = 0; k <= TE; k++) cyc(k, 1'b1, 1'b1, 1'b1, 1'b0, "b2b-R7", "");
        cyc(-1, 1'b0, 1'b0, 1'b1, 1'b0, "b2b-end", "R7");

        // R8: mode dropped and start re-pulsed during training
        cyc(0, 1'b1, 1'b1, 1'b1, 1'b0, "R8-train", "");
        for (int k = 1; k <= TE; k++)
            cyc(k, 1'b1, (k == 5 || k == 30) ? 1'b1 : 1'b0, (k < 10) ? 1'b1 : 1'b0, 1'b0, "R8-train", "");
        cyc(-1, 1'b0, 1'b0, 1'b0, 1'b0, "R8-end", "R8");

        // R8: mode raised and start re-pulsed during inference
        cyc(0, 1'b0, 1'b1, 1'b0, 1'b0, "R8-infer", "");
        for (int k = 1; k <= TF; k++)
            cyc(k, 1'b0, (k == 12) ? 1'b1 : 1'b0, 1'b1, 1'b0, "R8-infer", "");
        cyc(-1, 1'b0, 1'b0, 1'b0, 1'b0, "R8-end", "R8");

        // R9: reset in mid-iteration, then a fresh iteration
        cyc(0, 1'b1, 1'b1, 1'b1, 1'b0, "R9-pre", "");
        for (int k = 1; k < 20; k++) cyc(k, 1'b1, 1'b0, 1'b1, 1'b0, "R9-pre", "");
        cyc(-1, 1'b1, 1'b0, 1'b1, 1'b1, "R9-rst", "R9");
        for (int i = 0; i < 3; i++) cyc(-1, 1'b1, 1'b0, 1'b1, 1'b0, "R9-idle", "R9");
        cyc(0, 1'b1, 1'b1, 1'b1, 1'b0, "R9-restart", "R9");
        for (int k = 1; k <= TE; k++) cyc(k, 1'b1, 1'b0, 1'b1, 1'b0, "R9-restart", "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule